// File: doc/BRIEF.md
# Serial Divisible-by-Three Detector

This block watches a binary number that arrives one bit per clock, most significant bit first, and lights an output whenever the value seen so far is a multiple of three. A bit counts only on a clock edge where the valid strobe is high. On all other edges the block keeps its state. Appending bit b to a value N gives 2N+b. Because of this, the block does not keep the number. It keeps only N mod 3 in a two-bit register, so streams of any length use the same three states.

The state codes are 00, 01 and 10, meaning remainders 0, 1 and 2. Code 11 is not used, and the logic leaves it on the next edge. A synchronous reset returns the remainder to 0. The empty number is 0, so the light is on right after reset. The light is decoded from the state register alone (a Moore output). It therefore changes one clock after an accepted bit, never in the same cycle.

Top module: `mod3_stream_detector`

## Requirements
- R1: A clock edge with `rst` high sets the remainder to 0, so `divisible` reads 1 after that edge. This holds even if a valid bit is offered in the same cycle.
- R2: After each accepted bit, `divisible` is 1 exactly when the value formed by all accepted bits since reset (first bit most significant) is divisible by three.
- R3: From remainder 0 (code 00), an accepted 0 keeps remainder 0 and an accepted 1 moves to remainder 1 (code 01).
- R4: From remainder 1 (code 01), an accepted 0 moves to remainder 2 (code 10) and an accepted 1 moves to remainder 0.
- R5: From remainder 2 (code 10), an accepted 0 moves to remainder 1 and an accepted 1 stays at remainder 2.
- R6: On an edge with `bitValid` low, the remainder and `divisible` stay unchanged, whatever value `bitIn` has.
- R7: The remainder register never holds code 11. If it ever did, the next edge would return it to remainder 0. Streams up to 64 bits long give the same light as arithmetic on the full value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bitValid | input | 1 | High when `bitIn` carries the next bit of the number |
| bitIn | input | 1 | Next bit of the number, most significant first |
| divisible | output | 1 | High when the value entered so far is a multiple of three |

## Verification
Each result is due one rising edge after its stimulus. An accepted bit or a reset edge updates the remainder register, and `divisible` decodes that register with no further delay. The bench changes inputs on falling edges and reads `divisible` on the next falling edge, so each check falls half a period after the edge that should have updated it. Idle cycles with random `bitIn` are read in the same way, to confirm the light did not move. Expected values come from a remainder that the bench keeps by arithmetic. Every bit stream of length 1 to 8 is tried, followed by random streams of up to 64 bits with idle gaps inserted.

// File: rtl/mod3_pkg.sv
package mod3_pkg;

  typedef enum logic [1:0] {
    RES0    = 2'b00,
    RES1    = 2'b01,
    RES2    = 2'b10,
    RES_BAD = 2'b11
  } residue_t;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic clear;    // synchronous reset of the remainder
    logic recover;  // leave the unused code
    logic advance;  // fold the offered bit into the remainder
  } ctrl_t;

  // Remainder after appending bit b: (2N + b) mod 3.
  function automatic residue_t nextResidue(residue_t cur, logic b);
    residue_t nxt;
    case (cur)
      RES0:    nxt = b ? RES1 : RES0;
      RES1:    nxt = b ? RES0 : RES2;
      RES2:    nxt = b ? RES2 : RES1;
      default: nxt = RES0;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/mod3_ctrl.sv
module mod3_ctrl
  import mod3_pkg::*;
(
  input  logic     rst,
  input  logic     bitValid,
  input  residue_t residue,
  output ctrl_t    ctrl
);

  logic isBad;

  always_comb begin
    isBad        = (residue == RES_BAD);
    ctrl.clear   = rst;
    ctrl.recover = !rst && isBad;
    ctrl.advance = !rst && !isBad && bitValid;
  end

endmodule

// File: rtl/mod3_datapath.sv
module mod3_datapath
  import mod3_pkg::*;
(
  input  logic     clk,
  input  ctrl_t    ctrl,
  input  logic     bitIn,
  output residue_t residue,
  output logic     light
);

  residue_t residueReg;

  always_ff @(posedge clk) begin
    if (ctrl.clear || ctrl.recover)
      residueReg <= RES0;
    else if (ctrl.advance)
      residueReg <= nextResidue(residueReg, bitIn);
  end

  assign residue = residueReg;
  assign light   = (residueReg == RES0);

  // R3: steps out of remainder 0
  a_r3_from_zero: assert property (@(posedge clk) disable iff (ctrl.clear)
    (ctrl.advance && residueReg == RES0) |=> residueReg == ($past(bitIn) ? RES1 : RES0));

  // R4: steps out of remainder 1
  a_r4_from_one: assert property (@(posedge clk) disable iff (ctrl.clear)
    (ctrl.advance && residueReg == RES1) |=> residueReg == ($past(bitIn) ? RES0 : RES2));

  // R5: steps out of remainder 2
  a_r5_from_two: assert property (@(posedge clk) disable iff (ctrl.clear)
    (ctrl.advance && residueReg == RES2) |=> residueReg == ($past(bitIn) ? RES2 : RES1));

  // R6: no accepted bit, no change
  a_r6_hold: assert property (@(posedge clk) disable iff (ctrl.clear)
    (!ctrl.advance && !ctrl.recover) |=> $stable(residueReg) && $stable(light));

  // R7: unused code never reached
  a_r7_legal: assert property (@(posedge clk) disable iff (ctrl.clear)
    residueReg != RES_BAD);

  // R7: recovery path lands on remainder 0
  a_r7_recover: assert property (@(posedge clk) disable iff (ctrl.clear)
    ctrl.recover |=> residueReg == RES0);

endmodule

// File: rtl/mod3_stream_detector.sv
module mod3_stream_detector
  import mod3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bitValid,
  input  logic bitIn,
  output logic divisible
);

  ctrl_t    ctrl;
  residue_t residue;

  mod3_ctrl u_ctrl (
    .rst      (rst),
    .bitValid (bitValid),
    .residue  (residue),
    .ctrl     (ctrl)
  );

  mod3_datapath u_dp (
    .clk     (clk),
    .ctrl    (ctrl),
    .bitIn   (bitIn),
    .residue (residue),
    .light   (divisible)
  );

  // R1: a reset edge lights the output
  a_r1_reset_light: assert property (@(posedge clk) disable iff (!rst)
    rst |=> divisible);

endmodule

// File: tb/tb_mod3_stream_detector.sv
`timescale 1ns/1ps
module tb_mod3_stream_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitValid = 1'b0;
  logic bitIn = 1'b0;
  logic divisible;

  int checks = 0;
  int errors = 0;
  int refRes = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mod3_stream_detector dut (
    .clk       (clk),
    .rst       (rst),
    .bitValid  (bitValid),
    .bitIn     (bitIn),
    .divisible (divisible)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: divisible=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset(input logic offerBit);
    @(negedge clk);
    rst = 1'b1; bitValid = offerBit; bitIn = 1'b1;
    @(negedge clk);
    rst = 1'b0; bitValid = 1'b0;
    refRes = 0;
    check(divisible, 1'b1, "R1");
  endtask

  task automatic pushBit(input logic b);
    string req;
    case (refRes)
      0: req = "R3/R2";
      1: req = "R4/R2";
      default: req = "R5/R2";
    endcase
    bitValid = 1'b1; bitIn = b;
    refRes = (2 * refRes + int'(b)) % 3;
    @(negedge clk);
    bitValid = 1'b0;
    check(divisible, refRes == 0, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      bitValid = 1'b0; bitIn = 1'($urandom);
      @(negedge clk);
      check(divisible, refRes == 0, "R6");
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(divisible, 1'b1, "R1");
    // reset wins over an offered bit
    doReset(1'b1);
    // exhaustive streams of length 1..8
    for (int len = 1; len <= 8; len++) begin
      for (int v = 0; v < (1 << len); v++) begin
        doReset(1'b0);
        for (int k = len - 1; k >= 0; k--) pushBit(1'(v >> k));
        // R2 arithmetic cross-check of the whole value
        check(divisible, (v % 3) == 0, "R2");
      end
    end
    // R6: idle holds in each remainder
    doReset(1'b0);
    pushBit(1'b1); idle(4);
    pushBit(1'b0); idle(4);
    pushBit(1'b0); idle(4);
    // R7: long random streams with gaps
    for (int s = 0; s < 40; s++) begin
      int len = 1 + int'($urandom % 64);
      doReset(1'b0);
      for (int k = 0; k < len; k++) begin
        pushBit(1'($urandom));
        if (($urandom % 5) == 0) idle(1 + int'($urandom % 3));
      end
      check(divisible, refRes == 0, "R7");
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule